// File: doc/BRIEF.md
# Packed SIMD Multiply-Accumulate Unit

This unit is a pipelined arithmetic slice that treats each 64-bit operand as four 16-bit lanes (or eight bytes, for one reduction). One operation is issued per cycle. The caller presents two operands, a 64-bit accumulator value and a 4-bit opcode, and raises `in_valid`. The unit forms all lane products and the absolute-difference reductions combinationally. It picks the result named by the opcode and registers it.

The opcode set covers several multiply forms, each signed or unsigned: pairwise multiply-add into two 32-bit halves, per-lane low-half and high-half products, and a four-product sum widened to 64 bits. It also has two signed accumulate forms that add one or two halfword products to the accumulator input, and a sum of absolute differences over bytes or halfwords. The result appears one cycle after issue, with `out_valid`. The result then stays unchanged until the next issue.

Top module: `simd_mac_top`

## Requirements
- R1: Opcode 0 (unsigned) and opcode 1 (signed) perform pairwise multiply-add. Lane i is bits 16i+15:16i. Result bits 31:0 = lane0 product + lane1 product, and result bits 63:32 = lane2 product + lane3 product. Each sum is truncated to 32 bits.
- R2: Opcode 2 (unsigned) and opcode 3 (signed) write bits 15:0 of each lane's 16x16 product into that same lane of the result.
- R3: Opcode 4 (unsigned) and opcode 5 (signed) write bits 31:16 of each lane's 16x16 product into that same lane of the result.
- R4: Opcode 6 (unsigned) and opcode 7 (signed) return the sum of all four lane products, extended to 64 bits. In the signed form each product is sign-extended.
- R5: Opcode 8 returns the sum of |a-b| over the eight unsigned byte pairs, zero-extended to 64 bits.
- R6: Opcode 9 returns the sum of |a-b| over the four unsigned halfword pairs, zero-extended to 64 bits.
- R7: Opcode 10 forms the signed product of bits 15:0 of the two operands, sign-extends it to 64 bits and adds the accumulator input (modulo 2^64). All other operand bits are ignored.
- R8: Opcode 11 adds the sign-extended signed products of lane 0 and lane 1 to the accumulator input (modulo 2^64). Operand bits 63:32 are ignored.
- R9: Opcodes 12 to 15 return zero.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `result` carries that operation's value in that cycle.
- R11: When `in_valid` is low, `result` keeps its previous value, whatever the other inputs do.
- R12: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue strobe for the current inputs |
| op | input | 4 | Operation select |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| acc_in | input | 64 | Accumulator input for opcodes 10 and 11 |
| out_valid | output | 1 | Result strobe, one cycle after issue |
| result | output | 64 | Registered result |

## Verification
The properties in the RTL check the handshake and register behaviour on every cycle. They cover `out_valid` tracking `in_valid` one cycle later, `result` holding while nothing is issued, undefined opcodes yielding zero, the byte SAD staying within its 11-bit range, and reset clearing the outputs. The arithmetic cannot be checked that way. Correct truncation of pairwise sums, the choice between the low and high product halves, sign extension in signed forms versus zero extension in unsigned ones, and wrap-around of the accumulate forms are shown only by the bench's vectors. Those vectors use lanes of mixed sign and all-ones operands.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  localparam int WORD_W = 64;
  localparam int LANE_W = 16;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int PROD_W = 2 * LANE_W + 1;   // room for sign of unsigned product
  localparam int BYTE_W = 8;
  localparam int BYTES  = WORD_W / BYTE_W;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [3:0] {
    OP_PMADD_U = 4'd0,
    OP_PMADD_S = 4'd1,
    OP_MULLO_U = 4'd2,
    OP_MULLO_S = 4'd3,
    OP_MULHI_U = 4'd4,
    OP_MULHI_S = 4'd5,
    OP_MAC4_U  = 4'd6,
    OP_MAC4_S  = 4'd7,
    OP_SAD_B   = 4'd8,
    OP_SAD_H   = 4'd9,
    OP_ACC1    = 4'd10,
    OP_ACC2    = 4'd11
  } op_e;

  function automatic logic op_is_signed(input logic [3:0] code);
    case (code)
      OP_PMADD_S, OP_MULLO_S, OP_MULHI_S, OP_MAC4_S, OP_ACC1, OP_ACC2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/simd_lane_mul.sv
module simd_lane_mul #(
  parameter int LW    = 16,
  parameter int NL    = 4,
  localparam int PW   = 2 * LW + 1,
  localparam int IN_W = LW * NL
) (
  input  logic              sgn,
  input  logic [IN_W-1:0]   a,
  input  logic [IN_W-1:0]   b,
  output logic [NL*PW-1:0]  prod
);
  genvar i;
  generate
    for (i = 0; i < NL; i++) begin : g_lane
      logic [LW-1:0]        la, lb;
      logic signed [LW:0]   xa, xb;
      logic signed [2*LW+1:0] p;
      assign la = a[i*LW +: LW];
      assign lb = b[i*LW +: LW];
      assign xa = $signed({sgn & la[LW-1], la});
      assign xb = $signed({sgn & lb[LW-1], lb});
      assign p  = xa * xb;
      assign prod[i*PW +: PW] = p[PW-1:0];
    end
  endgenerate
endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
  parameter int DW = 64,
  parameter int BW = 8,
  parameter int HW = 16,
  localparam int NB = DW / BW,
  localparam int NH = DW / HW
) (
  input  logic          half_mode,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] db [NB];
  logic [DW-1:0] dh [NH];

  genvar i;
  generate
    for (i = 0; i < NB; i++) begin : g_byte
      logic [BW-1:0] x, y;
      assign x = a[i*BW +: BW];
      assign y = b[i*BW +: BW];
      assign db[i] = DW'((x > y) ? (x - y) : (y - x));
    end
    for (i = 0; i < NH; i++) begin : g_half
      logic [HW-1:0] x, y;
      assign x = a[i*HW +: HW];
      assign y = b[i*HW +: HW];
      assign dh[i] = DW'((x > y) ? (x - y) : (y - x));
    end
  endgenerate

  always_comb begin
    sum = '0;
    if (half_mode) begin
      for (int k = 0; k < NH; k++) sum = sum + dh[k];
    end else begin
      for (int k = 0; k < NB; k++) sum = sum + db[k];
    end
  end
endmodule

// File: rtl/simd_mac_top.sv
module simd_mac_top
  import simd_mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [WORD_W-1:0] acc_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  logic                    sgn;
  logic [LANES*PROD_W-1:0] prod;
  logic [WORD_W-1:0]       sad_sum;
  logic [WORD_W-1:0]       pe [LANES];
  logic [WORD_W-1:0]       mul_lo, mul_hi;
  logic [WORD_W-1:0]       pair_lo, pair_hi, mac4;
  logic [WORD_W-1:0]       nxt;

  assign sgn = op_is_signed(op);

  simd_lane_mul #(.LW(LANE_W), .NL(LANES)) u_mul (
    .sgn (sgn), .a (src_a), .b (src_b), .prod (prod)
  );

  simd_sad #(.DW(WORD_W), .BW(BYTE_W), .HW(LANE_W)) u_sad (
    .half_mode (op == OP_SAD_H), .a (src_a), .b (src_b), .sum (sad_sum)
  );

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_ext
      logic [PROD_W-1:0] p;
      assign p      = prod[i*PROD_W +: PROD_W];
      assign pe[i]  = {{(WORD_W-PROD_W){p[PROD_W-1]}}, p};
      assign mul_lo[i*LANE_W +: LANE_W] = p[LANE_W-1:0];
      assign mul_hi[i*LANE_W +: LANE_W] = p[2*LANE_W-1:LANE_W];
    end
  endgenerate

  assign pair_lo = pe[0] + pe[1];
  assign pair_hi = pe[2] + pe[3];

  always_comb begin
    mac4 = '0;
    for (int k = 0; k < LANES; k++) mac4 = mac4 + pe[k];
  end

  always_comb begin
    case (op)
      OP_PMADD_U, OP_PMADD_S: nxt = {pair_hi[HALF_W-1:0], pair_lo[HALF_W-1:0]};
      OP_MULLO_U, OP_MULLO_S: nxt = mul_lo;
      OP_MULHI_U, OP_MULHI_S: nxt = mul_hi;
      OP_MAC4_U,  OP_MAC4_S:  nxt = mac4;
      OP_SAD_B,   OP_SAD_H:   nxt = sad_sum;
      OP_ACC1:                nxt = acc_in + pe[0];
      OP_ACC2:                nxt = acc_in + pe[0] + pe[1];
      default:                nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  // R9
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd12) |=> (result == '0));
  // R5
  sadb_range_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SAD_B) |=> (result[WORD_W-1:11] == '0));
  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));
endmodule

// File: tb/tb_simd_mac_top.sv
`timescale 1ns/1ps
module tb_simd_mac_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op;
  logic [63:0] src_a, src_b, acc_in;
  logic        out_valid;
  logic [63:0] result;
  int          vectors = 0;
  int          miscompares = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  simd_mac_top dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .op (op),
    .src_a (src_a), .src_b (src_b), .acc_in (acc_in),
    .out_valid (out_valid), .result (result)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] acc;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    // R1 unsigned pairwise
    '{4'd1, 4'd0, 64'h0004_0003_0002_0001, 64'h0008_0007_0006_0005, 64'h0, 64'h00000035_00000011},
    // R1 signed pairwise, mixed signs
    '{4'd1, 4'd1, 64'hFFFF_0002_FFFE_0003, 64'h0005_0004_0007_0002, 64'h0, 64'h00000003_FFFFFFF8},
    // R1 truncation of each 32-bit sum
    '{4'd1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'hFFFC0002_FFFC0002},
    // R2 low halves, unsigned and signed
    '{4'd2, 4'd2, 64'h0100_0003_FFFF_1234, 64'h0100_0005_0002_0010, 64'h0, 64'h0000_000F_FFFE_2340},
    '{4'd2, 4'd3, 64'h0100_0003_FFFF_1234, 64'h0100_0005_0002_0010, 64'h0, 64'h0000_000F_FFFE_2340},
    // R3 high halves, unsigned and signed
    '{4'd3, 4'd4, 64'h0100_0003_FFFF_1234, 64'h0100_0005_0002_0010, 64'h0, 64'h0001_0000_0001_0001},
    '{4'd3, 4'd5, 64'h0100_0003_FFFF_1234, 64'h0100_0005_0002_0010, 64'h0, 64'h0001_0000_FFFF_0001},
    // R4 four-product sums
    '{4'd4, 4'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0000_0003_FFF8_0004},
    '{4'd4, 4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0000_0000_0000_0004},
    '{4'd4, 4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0005_0004_0003_0002, 64'h0, 64'hFFFF_FFFF_FFFF_FFF2},
    // R5 byte SAD
    '{4'd5, 4'd8, 64'h00FF_1020_0000_0503, 64'hFF00_2010_0000_0305, 64'h0, 64'h0000_0000_0000_0222},
    // R6 halfword SAD
    '{4'd6, 4'd9, 64'h0000_FFFF_0100_0010, 64'hFFFF_0000_0010_0100, 64'h0, 64'h0000_0000_0002_01DE},
    // R7 scalar accumulate, upper bits ignored
    '{4'd7, 4'd10, 64'h12345678_9ABC_FFFD, 64'h11111111_2222_0004, 64'h10, 64'h4},
    // R7 sign extension of the product
    '{4'd7, 4'd10, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001, 64'h0, 64'hFFFF_FFFF_FFFF_8000},
    // R8 dual accumulate, upper half ignored
    '{4'd8, 4'd11, 64'hDEADBEEF_0003_FFFE, 64'hCAFEF00D_0002_0005, 64'h100, 64'hFC},
    // R8 wrap-around
    '{4'd8, 4'd11, 64'h0000_0000_0001_0001, 64'h0000_0000_0001_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1},
    // R9 undefined opcodes
    '{4'd9, 4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    '{4'd9, 4'd15, 64'h0123_4567_89AB_CDEF, 64'h0011_2233_4455_6677, 64'h5, 64'h0}
  };

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
    @(negedge clk);
    op = o; src_a = a; src_b = b; acc_in = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op = 4'd0;
    src_a = '0; src_b = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R12", "result after reset", result, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].acc);
      check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d result", i), result, VECS[i].exp);
      // R10 valid with result
      check("R10", "out_valid with result", {63'd0, out_valid}, 64'd1);
    end

    // R10 out_valid drops the cycle after an idle issue slot
    @(negedge clk);
    check("R10", "out_valid idle", {63'd0, out_valid}, 64'd0);

    // R11 inputs change without in_valid: result holds
    op = 4'd7; src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = 64'h1234_1234_1234_1234;
    repeat (2) @(negedge clk);
    check("R11", "result held", result, 64'h0);
    check("R11", "out_valid low", {63'd0, out_valid}, 64'd0);

    // R10 back-to-back issues
    @(negedge clk);
    op = 4'd0; src_a = 64'h0004_0003_0002_0001; src_b = 64'h0008_0007_0006_0005; in_valid = 1'b1;
    @(negedge clk);
    check("R10", "first of pair", result, 64'h00000035_00000011);
    op = 4'd8; src_a = 64'h0000_0000_0000_00FF; src_b = 64'h0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "second of pair", result, 64'hFF);
    check("R10", "out_valid stays high", {63'd0, out_valid}, 64'd1);

    // R12 reset mid-run clears a nonzero result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R12", "result cleared", result, 64'h0);
    check("R12", "out_valid cleared", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule